// File: doc/BRIEF.md
# Word Stack Sequencer

This block carries out stack transfers of 16-bit words over a memory port that moves one byte per clock. A command selects a single-word store, a single-word restore, an eight-register save or an eight-register restore. The sequencer splits or assembles the bytes, steps the stack pointer downward on stores and upward on restores, and forms every byte address from a segment value and the pointer. It then hands back the new pointer, the restored word or words, and a one-cycle completion pulse.

The block sits between an instruction sequencer and a byte-wide memory. The client applies a command with the segment and pointer values and waits for the completion pulse. A restore whose target is the code segment register is refused at once, and the memory is never touched.

Top module: `stack_seq`

## Requirements
- R1: Each byte address is segIn*16 plus the current pointer, kept to 20 bits (it wraps modulo 2^20).
- R2: A single-word restore (cmdCode 2) reads the low byte at the pointer and the high byte at pointer+1. The bench samples memRdData one cycle after the address, and popWord returns {high, low}.
- R3: The pointer moves by 2 per word, down on stores and up on restores, modulo 65536. ptrOut holds the final pointer after completion.
- R4: A single-word store (cmdCode 1) writes the high byte of cmdWord at pointer-1 and then the low byte at pointer-2, one write per clock.
- R5: An eight-register save (cmdCode 3) stores the regsIn slots 0 to 7 (bits 16*i+15:16*i) in slot order, each word high byte first. Slot 4 (the pointer slot) stores the pointer value from before the sequence.
- R6: An eight-register restore (cmdCode 4) reads the words back into slots 7 down to 0 on popSetOut. The word read for slot 4 is dropped, so that slot reads zero, and popWord ends holding slot 0.
- R7: A restore with dstIsCode high pulses illegal together with done in the cycle after acceptance. It makes no memory access, and ptrOut equals ptrIn.
- R8: done is a one-cycle pulse. busy is high from the cycle after acceptance through the done cycle. Done arrives N cycles after the acceptance edge for N writes and N+1 cycles after it for N reads.
- R9: Commands that arrive while busy, and the codes 0, 5, 6 and 7, are ignored: they cause no access, no busy and no done.
- R10: After reset busy, done, illegal, memWrEn and memRdEn are low and ptrOut is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdCode | input | 3 | 1 store, 2 restore, 3 save eight, 4 restore eight |
| dstIsCode | input | 1 | Restore target is the code segment register |
| cmdWord | input | 16 | Word to store |
| segIn | input | 16 | Stack segment value |
| ptrIn | input | 16 | Starting stack pointer |
| regsIn | input | 128 | Eight register words, slot i at bits 16*i+15:16*i |
| memAddr | output | 20 | Byte address |
| memWrData | output | 8 | Byte to write |
| memWrEn | output | 1 | Byte write strobe |
| memRdEn | output | 1 | Byte read strobe |
| memRdData | input | 8 | Read byte, valid one cycle after the address |
| ptrOut | output | 16 | Updated stack pointer |
| popWord | output | 16 | Last restored word |
| popSetOut | output | 128 | Restored register set, same layout as regsIn |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Refused restore, with done |

## Verification
The assertions cover the properties that hold every cycle. Reads and writes never happen together, and there is no access while idle or on a refused restore. The pointer steps by one per byte access, a read is always followed by a capture, and done is a single pulse that ends busy. Only the bench scenarios can show the byte ordering, the addresses including both wrap cases, the save and restore slot order with the dropped pointer word, the exact completion latency, and that commands sent during a sequence leave the write stream unchanged.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  localparam int MAX_REGS = 8;
  localparam int STEP_W   = $clog2(2 * MAX_REGS);

  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_PUSH     = 3'd1,
    CMD_POP      = 3'd2,
    CMD_PUSH_ALL = 3'd3,
    CMD_POP_ALL  = 3'd4
  } stackCmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_READ, ST_DRAIN, ST_FIN
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              load;
    logic              wrAct;
    logic              rdAct;
    logic [STEP_W-1:0] stepIdx;
  } seqStrobe_t;
endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
#(
  parameter int REG_COUNT = MAX_REGS
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       dstIsCode,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       illegal
);
  localparam logic [STEP_W-1:0] LAST_ONE = STEP_W'(1);
  localparam logic [STEP_W-1:0] LAST_ALL = STEP_W'(2 * REG_COUNT - 1);

  seqState_e         stateQ;
  logic [STEP_W-1:0] stepQ;
  logic [STEP_W-1:0] lastQ;
  logic              illQ;
  logic              accept;

  always_comb begin
    accept = 1'b0;
    if (stateQ == ST_IDLE && cmdValid) begin
      accept = (cmdCode == CMD_PUSH) || (cmdCode == CMD_POP) ||
               (cmdCode == CMD_PUSH_ALL) || (cmdCode == CMD_POP_ALL);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      stepQ  <= '0;
      lastQ  <= '0;
      illQ   <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (accept) begin
            stepQ <= '0;
            illQ  <= 1'b0;
            case (cmdCode)
              CMD_PUSH: begin
                stateQ <= ST_WRITE;
                lastQ  <= LAST_ONE;
              end
              CMD_PUSH_ALL: begin
                stateQ <= ST_WRITE;
                lastQ  <= LAST_ALL;
              end
              CMD_POP: begin
                if (dstIsCode) begin
                  stateQ <= ST_FIN;
                  illQ   <= 1'b1;
                end else begin
                  stateQ <= ST_READ;
                  lastQ  <= LAST_ONE;
                end
              end
              default: begin
                stateQ <= ST_READ;
                lastQ  <= LAST_ALL;
              end
            endcase
          end
        end
        ST_WRITE: begin
          if (stepQ == lastQ) stateQ <= ST_FIN;
          else                stepQ  <= stepQ + 1'b1;
        end
        ST_READ: begin
          if (stepQ == lastQ) stateQ <= ST_DRAIN;
          else                stepQ  <= stepQ + 1'b1;
        end
        ST_DRAIN: stateQ <= ST_FIN;
        default:  stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load    = accept;
    strobe.wrAct   = (stateQ == ST_WRITE);
    strobe.rdAct   = (stateQ == ST_READ);
    strobe.stepIdx = stepQ;
  end

  assign busy    = (stateQ != ST_IDLE);
  assign done    = (stateQ == ST_FIN);
  assign illegal = done && illQ;

  // R8: completion is a single pulse that closes the busy window
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R9: a request seen while busy does not restart the sequence
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R7: a refused restore completes with no access
  a_r7_refuse_done: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (done && !strobe.wrAct && !strobe.rdAct));
endmodule

// File: rtl/stack_seq_dp.sv
module stack_seq_dp
  import stack_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter int REG_COUNT = MAX_REGS,
  parameter int SP_SLOT   = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqStrobe_t                    strobe,
  input  logic [2:0]                    cmdCode,
  input  logic [DATA_W-1:0]             cmdWord,
  input  logic [DATA_W-1:0]             segIn,
  input  logic [DATA_W-1:0]             ptrIn,
  input  logic [REG_COUNT*DATA_W-1:0]   regsIn,
  input  logic [DATA_W/2-1:0]           memRdData,
  output logic [DATA_W+SEG_SHIFT-1:0]   memAddr,
  output logic [DATA_W/2-1:0]           memWrData,
  output logic                          memWrEn,
  output logic                          memRdEn,
  output logic [DATA_W-1:0]             ptrOut,
  output logic [DATA_W-1:0]             popWord,
  output logic [REG_COUNT*DATA_W-1:0]   popSetOut
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int ADDR_W = DATA_W + SEG_SHIFT;
  localparam int WIDX_W = STEP_W - 1;

  logic [DATA_W-1:0]                  segQ, ptrQ, origQ, singleQ, popWordQ;
  logic                               allQ;
  logic [REG_COUNT-1:0][DATA_W-1:0]   pushSetQ;
  logic [REG_COUNT-1:0][DATA_W-1:0]   popSetQ;
  logic [BYTE_W-1:0]                  lowQ;
  logic                               rdPendQ;
  logic [STEP_W-1:0]                  pendIdxQ;

  logic [WIDX_W-1:0]                  wrWord;
  logic [WIDX_W-1:0]                  rdSlot;
  logic [DATA_W-1:0]                  srcWord;
  logic [DATA_W-1:0]                  offset;
  logic [DATA_W-1:0]                  joinWord;
  logic                               wordReady;

  // latch command operands and walk the pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      segQ     <= '0;
      ptrQ     <= '0;
      origQ    <= '0;
      singleQ  <= '0;
      allQ     <= 1'b0;
      pushSetQ <= '0;
    end else if (strobe.load) begin
      segQ     <= segIn;
      ptrQ     <= ptrIn;
      origQ    <= ptrIn;
      singleQ  <= cmdWord;
      allQ     <= (cmdCode == CMD_PUSH_ALL) || (cmdCode == CMD_POP_ALL);
      pushSetQ <= regsIn;
    end else if (strobe.wrAct) begin
      ptrQ <= ptrQ - 1'b1;
    end else if (strobe.rdAct) begin
      ptrQ <= ptrQ + 1'b1;
    end
  end

  // write byte selection
  always_comb begin
    wrWord = strobe.stepIdx[STEP_W-1:1];
    if (!allQ)                             srcWord = singleQ;
    else if (wrWord == WIDX_W'(SP_SLOT))   srcWord = origQ;
    else                                   srcWord = pushSetQ[wrWord];
    memWrData = strobe.stepIdx[0] ? srcWord[BYTE_W-1:0] : srcWord[DATA_W-1:BYTE_W];
  end

  // address: stores use pointer-1, restores use pointer
  always_comb begin
    offset  = strobe.wrAct ? (ptrQ - 1'b1) : ptrQ;
    memAddr = {segQ, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, offset};
  end

  assign memWrEn = strobe.wrAct;
  assign memRdEn = strobe.rdAct;

  // read capture, one cycle behind the address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPendQ  <= 1'b0;
      pendIdxQ <= '0;
      lowQ     <= '0;
      popWordQ <= '0;
    end else begin
      rdPendQ  <= strobe.rdAct;
      pendIdxQ <= strobe.stepIdx;
      if (rdPendQ && !pendIdxQ[0]) lowQ <= memRdData;
      if (wordReady)               popWordQ <= joinWord;
    end
  end

  always_comb begin
    wordReady = rdPendQ && pendIdxQ[0];
    joinWord  = {memRdData, lowQ};
    rdSlot    = WIDX_W'(REG_COUNT - 1) - pendIdxQ[STEP_W-1:1];
  end

  // one restore register per slot; the pointer slot stays empty
  for (genvar s = 0; s < REG_COUNT; s++) begin : g_slot
    if (s == SP_SLOT) begin : g_drop
      assign popSetQ[s] = '0;
    end else begin : g_keep
      logic [DATA_W-1:0] slotQ;
      always_ff @(posedge clk) begin
        if (!rstN)                                        slotQ <= '0;
        else if (wordReady && allQ && rdSlot == WIDX_W'(s)) slotQ <= joinWord;
      end
      assign popSetQ[s] = slotQ;
    end
  end

  assign ptrOut    = ptrQ;
  assign popWord   = popWordQ;
  assign popSetOut = popSetQ;

  // R3: every write moves the pointer down by one byte
  a_r3_write_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrAct |=> (ptrQ == DATA_W'($past(ptrQ) - 1'b1)));

  // R3: every read moves the pointer up by one byte
  a_r3_read_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdAct |=> (ptrQ == DATA_W'($past(ptrQ) + 1'b1)));

  // R2: each read address is followed by a capture cycle
  a_r2_capture_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdAct |=> rdPendQ);
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter int REG_COUNT = MAX_REGS,
  parameter int SP_SLOT   = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cmdValid,
  input  logic [2:0]                    cmdCode,
  input  logic                          dstIsCode,
  input  logic [DATA_W-1:0]             cmdWord,
  input  logic [DATA_W-1:0]             segIn,
  input  logic [DATA_W-1:0]             ptrIn,
  input  logic [REG_COUNT*DATA_W-1:0]   regsIn,
  output logic [DATA_W+SEG_SHIFT-1:0]   memAddr,
  output logic [DATA_W/2-1:0]           memWrData,
  output logic                          memWrEn,
  output logic                          memRdEn,
  input  logic [DATA_W/2-1:0]           memRdData,
  output logic [DATA_W-1:0]             ptrOut,
  output logic [DATA_W-1:0]             popWord,
  output logic [REG_COUNT*DATA_W-1:0]   popSetOut,
  output logic                          busy,
  output logic                          done,
  output logic                          illegal
);
  seqStrobe_t strobe;

  stack_seq_ctrl #(.REG_COUNT(REG_COUNT)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .dstIsCode(dstIsCode), .strobe(strobe), .busy(busy), .done(done),
    .illegal(illegal)
  );

  stack_seq_dp #(
    .DATA_W(DATA_W), .SEG_SHIFT(SEG_SHIFT), .REG_COUNT(REG_COUNT), .SP_SLOT(SP_SLOT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdCode(cmdCode), .cmdWord(cmdWord),
    .segIn(segIn), .ptrIn(ptrIn), .regsIn(regsIn), .memRdData(memRdData),
    .memAddr(memAddr), .memWrData(memWrData), .memWrEn(memWrEn), .memRdEn(memRdEn),
    .ptrOut(ptrOut), .popWord(popWord), .popSetOut(popSetOut)
  );

  // R1: one byte access per clock at most
  a_r1_single_access: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWrEn, memRdEn}));

  // R9: no memory traffic outside a sequence
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memWrEn && !memRdEn));
endmodule

// File: tb/stack_seq_tb_top.sv
module stack_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cmdValid = 1'b0;
  logic [2:0]   cmdCode = 3'd0;
  logic         dstIsCode = 1'b0;
  logic [15:0]  cmdWord = '0;
  logic [15:0]  segIn = '0;
  logic [15:0]  ptrIn = '0;
  logic [127:0] regsIn = '0;
  logic [19:0]  memAddr;
  logic [7:0]   memWrData;
  logic         memWrEn, memRdEn;
  logic [7:0]   memRdData = '0;
  logic [15:0]  ptrOut, popWord;
  logic [127:0] popSetOut;
  logic         busy, done, illegal;

  int testCnt = 0;
  int failCnt = 0;

  typedef struct packed { logic [19:0] addr; logic [7:0] data; } wrEv_t;
  wrEv_t expQ[$];
  logic [7:0] mem [logic [19:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_seq dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .dstIsCode(dstIsCode), .cmdWord(cmdWord), .segIn(segIn), .ptrIn(ptrIn),
    .regsIn(regsIn), .memAddr(memAddr), .memWrData(memWrData), .memWrEn(memWrEn),
    .memRdEn(memRdEn), .memRdData(memRdData), .ptrOut(ptrOut), .popWord(popWord),
    .popSetOut(popSetOut), .busy(busy), .done(done), .illegal(illegal)
  );

  // byte memory: writes land at the edge, read data one cycle after the address
  always @(posedge clk) begin
    if (memWrEn) mem[memAddr] = memWrData;
    memRdData <= mem.exists(memAddr) ? mem[memAddr] : 8'h00;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: every write must match the head of the scoreboard
  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9", "unexpected write addr", {12'h0, memAddr}, 32'h0);
      end else begin
        wrEv_t ev;
        ev = expQ.pop_front();
        check(memAddr == ev.addr, "R1", "write address", {12'h0, memAddr}, {12'h0, ev.addr});
        check(memWrData == ev.data, "R4", "write byte", {24'h0, memWrData}, {24'h0, ev.data});
      end
    end
  end

  function automatic logic [19:0] lin(input logic [15:0] seg, input logic [15:0] off);
    return {seg, 4'h0} + {4'h0, off};
  endfunction

  task automatic expWord(input logic [15:0] seg, inout logic [15:0] sp, input logic [15:0] w);
    expQ.push_back({lin(seg, sp - 16'd1), w[15:8]});
    expQ.push_back({lin(seg, sp - 16'd2), w[7:0]});
    sp = sp - 16'd2;
  endtask

  task automatic runCmd(input logic [2:0] code, input logic [15:0] word,
                        input logic [15:0] seg, input logic [15:0] sp, input logic dst,
                        input int expLat, input bit intrude, output logic ill);
    int k;
    @(negedge clk);
    cmdCode = code; cmdWord = word; segIn = seg; ptrIn = sp; dstIsCode = dst;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    k = 0;
    while (!done && k < 40) begin
      if (intrude && k == 2) begin
        cmdValid = 1'b1; cmdCode = 3'd1; cmdWord = 16'h5555; ptrIn = 16'h0800;
      end else begin
        cmdValid = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    cmdValid = 1'b0;
    check(k == expLat, "R8", "done latency", k, expLat);
    check(busy == 1'b1, "R8", "busy in done cycle", {31'h0, busy}, 32'h1);
    ill = illegal;
    @(negedge clk);
    check(!done && !busy, "R8", "done pulse ended", {30'h0, done, busy}, 32'h0);
    check(expQ.size() == 0, "R4", "pending writes", expQ.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic        ill;
    logic [15:0] sp;
    logic [15:0] regs [8];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!busy && !done && !illegal, "R10", "flags after reset", {29'h0, busy, done, illegal}, 32'h0);
    check(!memWrEn && !memRdEn, "R10", "strobes after reset", {30'h0, memWrEn, memRdEn}, 32'h0);
    check(ptrOut == 16'h0, "R10", "pointer after reset", {16'h0, ptrOut}, 32'h0);

    // R4/R3 single store
    sp = 16'h0100; expWord(16'h1000, sp, 16'hABCD);
    runCmd(3'd1, 16'hABCD, 16'h1000, 16'h0100, 1'b0, 2, 1'b0, ill);
    check(ptrOut == 16'h00FE, "R3", "pointer after store", {16'h0, ptrOut}, 32'h00FE);
    check(ill == 1'b0, "R7", "no refusal on store", {31'h0, ill}, 32'h0);

    // R2 restore
    runCmd(3'd2, 16'h0, 16'h1000, 16'h00FE, 1'b0, 3, 1'b0, ill);
    check(popWord == 16'hABCD, "R2", "restored word", {16'h0, popWord}, 32'hABCD);
    check(ptrOut == 16'h0100, "R3", "pointer after restore", {16'h0, ptrOut}, 32'h0100);

    // R3 pointer wrap through zero
    sp = 16'h0001; expWord(16'hF000, sp, 16'h1234);
    runCmd(3'd1, 16'h1234, 16'hF000, 16'h0001, 1'b0, 2, 1'b0, ill);
    check(ptrOut == 16'hFFFF, "R3", "pointer wrap down", {16'h0, ptrOut}, 32'hFFFF);
    runCmd(3'd2, 16'h0, 16'hF000, 16'hFFFF, 1'b0, 3, 1'b0, ill);
    check(popWord == 16'h1234, "R2", "word across wrap", {16'h0, popWord}, 32'h1234);
    check(ptrOut == 16'h0001, "R3", "pointer wrap up", {16'h0, ptrOut}, 32'h0001);

    // R1 20-bit address wrap
    sp = 16'h0020; expWord(16'hFFFF, sp, 16'h00FF);
    runCmd(3'd1, 16'h00FF, 16'hFFFF, 16'h0020, 1'b0, 2, 1'b0, ill);
    check(mem[20'h0000F] == 8'h00 && mem[20'h0000E] == 8'hFF, "R1", "wrapped address bytes",
          {16'h0, mem[20'h0000F], mem[20'h0000E]}, 32'h00FF);

    // R2 restore from preloaded bytes
    mem[20'h20040] = 8'h5A; mem[20'h20041] = 8'hC3;
    runCmd(3'd2, 16'h0, 16'h2000, 16'h0040, 1'b0, 3, 1'b0, ill);
    check(popWord == 16'hC35A, "R2", "low byte first", {16'h0, popWord}, 32'hC35A);

    // R5 save eight, with an intruding request (R9)
    for (int i = 0; i < 8; i++) begin
      regs[i] = 16'h1111 * 16'(i + 1) ^ 16'h0F0F;
      regsIn[16*i +: 16] = regs[i];
    end
    sp = 16'h0200;
    for (int i = 0; i < 8; i++) expWord(16'h3000, sp, (i == 4) ? 16'h0200 : regs[i]);
    runCmd(3'd3, 16'h0, 16'h3000, 16'h0200, 1'b0, 16, 1'b1, ill);
    check(ptrOut == 16'h01F0, "R5", "pointer after save", {16'h0, ptrOut}, 32'h01F0);

    // R6 restore eight
    regsIn = '0;
    runCmd(3'd4, 16'h0, 16'h3000, 16'h01F0, 1'b0, 17, 1'b0, ill);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] e;
      e = (i == 4) ? 16'h0000 : regs[i];
      check(popSetOut[16*i +: 16] == e, "R6", $sformatf("slot %0d", i),
            {16'h0, popSetOut[16*i +: 16]}, {16'h0, e});
    end
    check(ptrOut == 16'h0200, "R6", "pointer after restore eight", {16'h0, ptrOut}, 32'h0200);
    check(popWord == regs[0], "R6", "last restored word", {16'h0, popWord}, {16'h0, regs[0]});

    // R7 refused restore
    runCmd(3'd2, 16'h0, 16'h1000, 16'h0300, 1'b1, 0, 1'b0, ill);
    check(ill == 1'b1, "R7", "refusal flag", {31'h0, ill}, 32'h1);
    check(ptrOut == 16'h0300, "R7", "pointer kept", {16'h0, ptrOut}, 32'h0300);

    // R9 unused codes
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c > 4) begin
        @(negedge clk);
        cmdCode = 3'(c); cmdValid = 1'b1;
        @(negedge clk);
        cmdValid = 1'b0;
        check(!busy && !done && !memRdEn, "R9", $sformatf("code %0d ignored", c),
              {29'h0, busy, done, memRdEn}, 32'h0);
        @(negedge clk);
        check(!busy && !done && ptrOut == 16'h0300, "R9", "still idle",
              {14'h0, busy, done, ptrOut}, {16'h0, 16'h0300});
      end
    end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule